// File: doc/BRIEF.md
# Debug Halt Controller

This block decides when a processor core stops normal execution and parks in a dormant debug halt state, and when it resumes. A halt can be requested in three ways: a one-cycle begin command from the test-port instruction decoder, an external active-low run/stop pin, and a debug exception that is steered into halt mode by an enable bit of the debug control register. While halted, the block stalls the fetch and decode stages, keeps exceptions, NMI and external interrupts pending, and raises a halt-ready output that tells the debug host halt-mode commands may be issued.

The block remembers which source caused the halt, because the legal ways out differ. A halt begun by the test port or by a debug exception ends on an end command or on a full high-low-high cycle of the run/stop pin. A halt begun by the pin ends only when the pin returns high, and an end command is then ignored. When the enable bit is clear, a debug exception requests the normal exception handler instead.

The states are RUN (normal execution), WAIT_BND (fetch stalled, waiting for the current instruction to reach its boundary), HALT_TAP, HALT_PIN and HALT_DBG (halted, tagged by cause). Transitions: RUN to WAIT_BND on a begin command; WAIT_BND to HALT_TAP at the boundary; RUN or WAIT_BND to HALT_PIN when the synchronized pin is low (highest priority); RUN or WAIT_BND to HALT_DBG on an enabled debug exception; HALT_TAP or HALT_DBG to RUN on an end command or an armed pin rise; HALT_PIN to RUN when the synchronized pin is high.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: A begin command in RUN moves the block to WAIT_BND at the next clock edge (fetch stall high, halt-ready low); at the first edge where the instruction-boundary input is high it enters HALT_TAP and halt-ready rises.
- R2: In HALT_TAP or HALT_DBG, an end command returns the block to RUN at the next edge, dropping halt-ready, stall and hold together; an end command in RUN has no effect.
- R3: In HALT_TAP or HALT_DBG, a high-to-low pin transition seen while halted arms the pin exit, and the following low-to-high transition returns the block to RUN at the third clock edge after the pin rises.
- R4: The run/stop pin passes through a two-flop synchronizer; with the pin held low, the block enters HALT_PIN at the third edge after it falls, from RUN or WAIT_BND, with priority over a debug exception and a begin command.
- R5: In HALT_PIN, an end command is ignored, and the block returns to RUN at the third edge after the pin returns high.
- R6: With the halt-on-exception enable at 1, any bit of the debug-exception source vector (bit 0 breakpoint match, bit 1 single-step trap, bit 2 task switch into a trapping task, bit 3 debug-register access under general detect, bit 4 debug-trap instruction) moves the block from RUN to HALT_DBG at the next edge.
- R7: With the enable at 0, a debug-exception source bit raises the handler-request output in the same cycle and causes no halt; the handler request is held low in every halted state.
- R8: In all three halted states halt-ready, fetch stall and interrupt hold are all high; in WAIT_BND only fetch stall is high; in RUN all three are low.
- R9: Reset returns the block to RUN from any state, with all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| tap_begin_i | input | 1 | Begin-halt command pulse from the test-port decoder |
| tap_end_i | input | 1 | End-halt command pulse from the test-port decoder |
| run_stop_n_i | input | 1 | Asynchronous run/stop pin, low requests halt |
| insn_boundary_i | input | 1 | Core is at an instruction boundary |
| halt_on_exc_i | input | 1 | Bit 0 of the debug control register: steer debug exceptions into halt mode |
| dbg_exc_i | input | N_EXC_SRC | Debug-exception source strobes, one bit per source |
| halt_ready_o | output | 1 | Halted and ready for halt-mode commands |
| fetch_stall_o | output | 1 | Stall to fetch and decode |
| irq_hold_o | output | 1 | Keep exceptions, NMI and interrupts pending |
| exc_handler_req_o | output | 1 | Request the normal debug exception handler |

## Verification
Commands and debug exceptions act at the first clock edge after they are applied, so the state-driven outputs are due just after that edge; the handler request is combinational and is due in the same cycle as its source. Any pin change takes three edges to reach the outputs, two for the synchronizer and one for the state register. The bench drives every input on the falling clock edge and samples one nanosecond after the rising edge, and its vector table lists the expected outputs per edge, so each pin scenario holds the pin for the full three edges before the change is expected.

// File: rtl/dhc_pkg.sv
package dhc_pkg;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_WAIT_BND = 3'd1,
        ST_HALT_TAP = 3'd2,
        ST_HALT_PIN = 3'd3,
        ST_HALT_DBG = 3'd4
    } dhc_state_e;

    function automatic logic dhc_is_halted(dhc_state_e s);
        return (s == ST_HALT_TAP) || (s == ST_HALT_PIN) || (s == ST_HALT_DBG);
    endfunction

    function automatic logic dhc_soft_exit(dhc_state_e s);
        return (s == ST_HALT_TAP) || (s == ST_HALT_DBG);
    endfunction

endpackage

// File: rtl/dhc_pin_sync.sv
module dhc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic fall_o,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= pin_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level_o = chain_q[STAGES-1];
    assign fall_o  = prev_q & ~chain_q[STAGES-1];
    assign rise_o  = ~prev_q & chain_q[STAGES-1];
endmodule

// File: rtl/dhc_exc_gate.sv
module dhc_exc_gate #(
    parameter int N_SRC = 5
) (
    input  logic [N_SRC-1:0] src_i,
    input  logic             enable_i,
    input  logic             halted_i,
    output logic             halt_hit_o,
    output logic             handler_req_o
);
    logic any_src;

    assign any_src       = |src_i;
    assign halt_hit_o    = any_src & enable_i & ~halted_i;
    assign handler_req_o = any_src & ~enable_i & ~halted_i;
endmodule

// File: rtl/dhc_fsm.sv
module dhc_fsm
    import dhc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tap_begin_i,
    input  logic       tap_end_i,
    input  logic       boundary_i,
    input  logic       pin_low_i,
    input  logic       pin_fall_i,
    input  logic       pin_rise_i,
    input  logic       exc_hit_i,
    output dhc_state_e state_o,
    output logic       halt_ready_o,
    output logic       fetch_stall_o,
    output logic       irq_hold_o
);
    dhc_state_e state_q, state_d;
    logic       armed_q, armed_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (pin_low_i)        state_d = ST_HALT_PIN;
                else if (exc_hit_i)   state_d = ST_HALT_DBG;
                else if (tap_begin_i) state_d = ST_WAIT_BND;
            end
            ST_WAIT_BND: begin
                if (pin_low_i)        state_d = ST_HALT_PIN;
                else if (exc_hit_i)   state_d = ST_HALT_DBG;
                else if (boundary_i)  state_d = ST_HALT_TAP;
            end
            ST_HALT_TAP, ST_HALT_DBG: begin
                if (tap_end_i || (pin_rise_i && armed_q)) state_d = ST_RUN;
            end
            ST_HALT_PIN: begin
                if (!pin_low_i)       state_d = ST_RUN;
            end
            default:                  state_d = ST_RUN;
        endcase
    end

    always_comb begin
        if (dhc_soft_exit(state_q) && dhc_soft_exit(state_d))
            armed_d = armed_q | pin_fall_i;
        else
            armed_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            armed_q <= 1'b0;
        end else begin
            state_q <= state_d;
            armed_q <= armed_d;
        end
    end

    always_comb begin
        halt_ready_o  = 1'b0;
        fetch_stall_o = 1'b0;
        irq_hold_o    = 1'b0;
        unique case (state_q)
            ST_RUN: ;
            ST_WAIT_BND: fetch_stall_o = 1'b1;
            ST_HALT_TAP, ST_HALT_PIN, ST_HALT_DBG: begin
                halt_ready_o  = 1'b1;
                fetch_stall_o = 1'b1;
                irq_hold_o    = 1'b1;
            end
            default: ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
    import dhc_pkg::*;
#(
    parameter int N_EXC_SRC   = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tap_begin_i,
    input  logic                 tap_end_i,
    input  logic                 run_stop_n_i,
    input  logic                 insn_boundary_i,
    input  logic                 halt_on_exc_i,
    input  logic [N_EXC_SRC-1:0] dbg_exc_i,
    output logic                 halt_ready_o,
    output logic                 fetch_stall_o,
    output logic                 irq_hold_o,
    output logic                 exc_handler_req_o
);
    dhc_state_e state_q;
    logic       pin_level, pin_fall, pin_rise;
    logic       exc_hit;

    dhc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (run_stop_n_i),
        .level_o (pin_level),
        .fall_o  (pin_fall),
        .rise_o  (pin_rise)
    );

    dhc_exc_gate #(.N_SRC(N_EXC_SRC)) u_gate (
        .src_i         (dbg_exc_i),
        .enable_i      (halt_on_exc_i),
        .halted_i      (irq_hold_o),
        .halt_hit_o    (exc_hit),
        .handler_req_o (exc_handler_req_o)
    );

    dhc_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .tap_begin_i   (tap_begin_i),
        .tap_end_i     (tap_end_i),
        .boundary_i    (insn_boundary_i),
        .pin_low_i     (~pin_level),
        .pin_fall_i    (pin_fall),
        .pin_rise_i    (pin_rise),
        .exc_hit_i     (exc_hit),
        .state_o       (state_q),
        .halt_ready_o  (halt_ready_o),
        .fetch_stall_o (fetch_stall_o),
        .irq_hold_o    (irq_hold_o)
    );
endmodule

// File: rtl/dhc_checker.sv
module dhc_checker
    import dhc_pkg::*;
#(
    parameter int N_SRC = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dhc_state_e       state,
    input  logic             pin_level,
    input  logic             tap_begin,
    input  logic             tap_end,
    input  logic             boundary,
    input  logic             en,
    input  logic [N_SRC-1:0] src,
    input  logic             ready,
    input  logic             stall,
    input  logic             hold,
    input  logic             handler_req
);
    assert_wait_to_tap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_BND && boundary && pin_level && !(en && src != '0))
        |=> (state == ST_HALT_TAP));

    assert_end_exits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_HALT_TAP || state == ST_HALT_DBG) && tap_end) |=> !ready);

    assert_pin_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !pin_level) |=> (state == ST_HALT_PIN));

    assert_pin_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT_PIN && !pin_level) |=> ready);

    assert_exc_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && pin_level && en && src != '0) |=> (state == ST_HALT_DBG));

    assert_no_halt_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && pin_level && !en && !tap_begin) |=> (state == ST_RUN));

    assert_req_not_halted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        handler_req |-> !ready);

    assert_halt_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (stall && hold));

    assert_ready_enter_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(stall || !pin_level || (en && src != '0)));
endmodule

bind dbg_halt_ctrl dhc_checker #(.N_SRC(N_EXC_SRC)) u_dhc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state_q),
    .pin_level   (pin_level),
    .tap_begin   (tap_begin_i),
    .tap_end     (tap_end_i),
    .boundary    (insn_boundary_i),
    .en          (halt_on_exc_i),
    .src         (dbg_exc_i),
    .ready       (halt_ready_o),
    .stall       (fetch_stall_o),
    .hold        (irq_hold_o),
    .handler_req (exc_handler_req_o)
);

// File: tb/tb_dbg_halt_ctrl.sv
`timescale 1ns/1ps
module tb_dbg_halt_ctrl;
    localparam int NSRC = 5;
    localparam int NVEC = 43;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tap_begin = 1'b0, tap_end = 1'b0, pin_n = 1'b1, bnd = 1'b0, en = 1'b0;
    logic [NSRC-1:0] src = '0;
    logic ready, stall, hold, req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dbg_halt_ctrl #(.N_EXC_SRC(NSRC), .SYNC_STAGES(2)) dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .tap_begin_i       (tap_begin),
        .tap_end_i         (tap_end),
        .run_stop_n_i      (pin_n),
        .insn_boundary_i   (bnd),
        .halt_on_exc_i     (en),
        .dbg_exc_i         (src),
        .halt_ready_o      (ready),
        .fetch_stall_o     (stall),
        .irq_hold_o        (hold),
        .exc_handler_req_o (req)
    );

    // {tag, tap_begin, tap_end, pin_n, boundary, enable, source[4:0], ready, stall, hold, req}
    localparam logic [17:0] VEC [NVEC] = '{
        18'b1001_00100_00000_0000, // R9 idle
        18'b0001_10100_00000_0100, // R1 begin, no boundary
        18'b0001_00100_00000_0100, // R1 still waiting
        18'b0001_00110_00000_1110, // R1 boundary reached
        18'b1000_00101_00001_1110, // R8 exception ignored while halted
        18'b1000_00100_00001_1110, // R8 no handler request while halted
        18'b0010_01100_00000_0000, // R2 end command
        18'b0010_00100_00000_0000, // R2
        18'b0100_00000_00000_0000, // R4 pin low, sync stage 1
        18'b0100_00000_00000_0000, // R4 sync stage 2
        18'b0100_00000_00000_1110, // R4 halted by pin
        18'b0101_01000_00000_1110, // R5 end ignored
        18'b0101_00100_00000_1110, // R5 pin high
        18'b0101_00100_00000_1110, // R5
        18'b0101_00100_00000_0000, // R5 exit
        18'b0111_00100_00010_0001, // R7 handler request
        18'b0110_00101_00010_1110, // R6 single-step halt
        18'b0011_00000_00000_1110, // R3 pin falls
        18'b0011_00000_00000_1110, // R3
        18'b0011_00000_00000_1110, // R3 armed
        18'b0011_00000_00000_1110, // R3
        18'b0011_00100_00000_1110, // R3 pin rises
        18'b0011_00100_00000_1110, // R3
        18'b0011_00100_00000_0000, // R3 exit
        18'b0011_00100_00000_0000, // R3
        18'b0110_00101_10000_1110, // R6 trap instruction
        18'b0010_01100_00000_0000, // R2
        18'b0110_00101_00100_1110, // R6 task switch trap
        18'b0010_01100_00000_0000, // R2
        18'b0110_00101_00001_1110, // R6 breakpoint
        18'b0010_01100_00000_0000, // R2
        18'b0110_00101_01000_1110, // R6 general detect
        18'b0010_01100_00000_0000, // R2
        18'b0001_10110_00000_0100, // R1 begin at boundary
        18'b0001_00110_00000_1110, // R1
        18'b0011_00000_00000_1110, // R3 pin cycle after test-port halt
        18'b0011_00000_00000_1110, // R3
        18'b0011_00000_00000_1110, // R3
        18'b0011_00100_00000_1110, // R3
        18'b0011_00100_00000_1110, // R3
        18'b0011_00100_00000_0000, // R3 exit
        18'b0010_01100_00000_0000, // R2 end in RUN has no effect
        18'b0111_00100_10000_0001  // R7
    };

    task automatic check(input string rq, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {ready,stall,hold,req} actual %b expected %b", rq, act, exp);
        end
    endtask

    task automatic drive(input logic [9:0] v);
        {tap_begin, tap_end, pin_n, bnd, en, src} = v;
    endtask

    task automatic step_check(input string rq, input logic [9:0] v, input logic [3:0] exp);
        @(negedge clk);
        drive(v);
        @(posedge clk);
        #1;
        check(rq, {ready, stall, hold, req}, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual expired expected finished");
        finish_run();
    end

    initial begin
        // R9: outputs low while in reset
        #1;
        check("R9", {ready, stall, hold, req}, 4'b0000);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            automatic logic [17:0] e = VEC[i];
            step_check($sformatf("R%0d vec%0d", e[17:14], i), e[13:4], e[3:0]);
        end

        // R4 corner: pin low during WAIT_BND takes over the pending test-port halt
        step_check("R1 wait", 10'b10100_00000, 4'b0100);
        step_check("R4 wait", 10'b00000_00000, 4'b0100);
        step_check("R4 wait", 10'b00000_00000, 4'b0100);
        step_check("R4 wait", 10'b00010_00000, 4'b1110);
        // R5: end command ignored after pin entry
        step_check("R5", 10'b01000_00000, 4'b1110);
        step_check("R5", 10'b00100_00000, 4'b1110);
        step_check("R5", 10'b00100_00000, 4'b1110);
        step_check("R5", 10'b00100_00000, 4'b0000);

        // R9: reset while halted returns to RUN
        step_check("R6 pre", 10'b00101_00001, 4'b1110);
        @(negedge clk);
        drive(10'b00100_00000);
        rst_n = 1'b0;
        #1;
        check("R9 mid-halt", {ready, stall, hold, req}, 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;
        step_check("R9 after", 10'b00100_00000, 4'b0000);

        finish_run();
    end
endmodule